// File: doc/BRIEF.md
# Five-Bank Multiplexed Segment Scanner

This block lights a common-cathode display of five banks, one bank at a time. Each bank carries a seven-segment digit and a decimal segment. From a 24-bit display word and a 7-bit configuration word it steps through the banks in a fixed order. For each bank it picks that bank's 4-bit nibble and turns it into segment drive, either through a hexadecimal character decoder or as raw lamp bits. It also drives the decimal segment from its own bit in the display word. Only one bank select is high at any time.

A prescaler, set by a parameter, fixes how many system clocks each bank keeps. By default that count comes from the system clock rate and a target refresh rate, so the whole display refreshes within the 700 to 1900 Hz window. The first clock of every bank slot is a dead clock in which no bank is on, so a new segment pattern never reaches the bank that was just lit. A low-power bit blanks every output and freezes the scan. A dim bit is passed on to the analog drivers. After reset the display stays dark until the register file signals the first write of the display word.

Top module: `mux_display_scan`

## Requirements
- R1: While reset is asserted, and after reset until the first clock edge at which `upd_i` is high, `bank_o`, `seg_o` and `dp_o` are all zero.
- R2: Bank slot k (k = 0..4) drives `bank_o` = 1<<k. Slots follow each other 0,1,2,3,4,0,... and each slot lasts DWELL_CLKS clocks. Outputs are registered, so they show the inputs and scan state sampled at the previous rising edge.
- R3: In the first clock of every slot `bank_o` is zero, and in the remaining DWELL_CLKS-1 clocks the slot's bank is on. No clock ever has two banks on.
- R4: In decode mode, slot k takes nibble `disp_word[4k+3:4k]`. `seg_o` (bit 0 = segment a ... bit 6 = segment g) shows: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, B=7C, C=39, D=5E, E=79, F=71 (hex).
- R5: When `cfg_word[1+k]` is 1, slot k is in raw mode: `seg_o` = {3'b000, nibble}, so nibble bit i drives segment a+i.
- R6: During slot k (k = 0..3) `dp_o` equals `disp_word[20+k]`. During slot 4 `dp_o` is 0.
- R7: While `cfg_word[0]` is 1 (low power), the next clock has all of `bank_o`, `seg_o` and `dp_o` at zero. The scan position is held, and when the bit clears the scan resumes from that same position.
- R8: `dim_o` equals `cfg_word[6]` sampled at the previous rising edge, and low power does not affect it.
- R9: Whenever `bank_o` is zero, `seg_o` and `dp_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | High for one clock when the display word has been written |
| disp_word | input | 24 | Bank nibbles in [19:0], decimal bits for banks 0..3 in [23:20] |
| cfg_word | input | 7 | [0] low power, [5:1] raw mode per bank, [6] dim |
| seg_o | output | 7 | Segment drive, bit 0 = a ... bit 6 = g |
| dp_o | output | 1 | Decimal segment drive |
| bank_o | output | 5 | One-hot bank select, bit k = bank k |
| dim_o | output | 1 | Reduced drive level request |

## Verification
If the prescaler count is corrupted, `bank_o` either skips its dead clock or keeps a bank longer than DWELL_CLKS. This shows up within one slot. A bad scan index lights the wrong bank, or shows a neighbour's nibble and decimal bit on the right bank. The error appears at the next slot boundary and stays for that whole slot. A lost display-written flag keeps the display dark, or lights it before any write. A scan that does not freeze in low power resumes on the wrong bank on the first clock after the bit clears. A cycle-accurate reference compares every output on every clock, so each of these is caught within one scan round.

// File: rtl/mux_scan_pkg.sv
package mux_scan_pkg;

  localparam int unsigned BANKS    = 5;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned SEG_W    = 7;
  localparam int unsigned IDX_W    = $clog2(BANKS);
  localparam int unsigned DP_BITS  = BANKS - 1;
  localparam int unsigned DP_BASE  = BANKS * NIB_W;
  localparam int unsigned DISP_W   = DP_BASE + DP_BITS;
  localparam int unsigned CFG_LP   = 0;
  localparam int unsigned CFG_RAW0 = 1;
  localparam int unsigned CFG_DIM  = CFG_RAW0 + BANKS;
  localparam int unsigned CFG_W    = CFG_DIM + 1;

  // Clocks per bank slot for a wanted full-display refresh rate.
  function automatic int unsigned dwell_for(input int unsigned clk_hz,
                                            input int unsigned refresh_hz);
    return clk_hz / (refresh_hz * BANKS);
  endfunction

  // Hex character decode, bit 0 = segment a ... bit 6 = segment g.
  function automatic logic [SEG_W-1:0] hex7(input logic [NIB_W-1:0] n);
    logic [SEG_W-1:0] s;
    case (n)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

  // Raw lamp mode: nibble bit i drives segment a+i.
  function automatic logic [SEG_W-1:0] raw7(input logic [NIB_W-1:0] n);
    return {{(SEG_W-NIB_W){1'b0}}, n};
  endfunction

  function automatic logic [BANKS-1:0] bank_onehot(input logic [IDX_W-1:0] i);
    logic [BANKS-1:0] v;
    v = '0;
    for (int k = 0; k < BANKS; k++) begin
      if (i == IDX_W'(k)) v[k] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import mux_scan_pkg::*;
#(
  parameter int unsigned DWELL = 8,
  localparam int unsigned CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [IDX_W-1:0] idx_o,
  output logic             dead_o,
  output logic             slot_end_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_clk;
  logic             last_bank;

  assign last_clk   = (cnt_q == CNT_W'(DWELL - 1));
  assign last_bank  = (idx_q == IDX_W'(BANKS - 1));
  assign slot_end_o = run && last_clk;
  assign dead_o     = (cnt_q == '0);
  assign idx_o      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (run) begin
      if (last_clk) begin
        cnt_q <= '0;
        idx_q <= last_bank ? '0 : idx_q + IDX_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/bank_select.sv
module bank_select
  import mux_scan_pkg::*;
(
  input  logic [DISP_W-1:0] disp_word,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [IDX_W-1:0]  idx,
  output logic [SEG_W-1:0]  seg,
  output logic              dp
);

  logic [BANKS-1:0][NIB_W-1:0] nib_arr;
  logic [BANKS-1:0]            dp_arr;
  logic [BANKS-1:0]            raw_arr;
  logic [NIB_W-1:0]            nib;

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    assign nib_arr[k] = disp_word[k*NIB_W +: NIB_W];
    assign raw_arr[k] = cfg_word[CFG_RAW0 + k];
    if (k < DP_BITS) begin : g_dp
      assign dp_arr[k] = disp_word[DP_BASE + k];
    end else begin : g_nodp
      assign dp_arr[k] = 1'b0;
    end
  end

  assign nib = nib_arr[idx];
  assign dp  = dp_arr[idx];
  assign seg = raw_arr[idx] ? raw7(nib) : hex7(nib);

endmodule

// File: rtl/drive_stage.sv
module drive_stage
  import mux_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             lp,
  input  logic             dead,
  input  logic [IDX_W-1:0] idx,
  input  logic [SEG_W-1:0] seg,
  input  logic             dp,
  input  logic             dim,
  output logic             shown_o,
  output logic [BANKS-1:0] bank_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             dp_o,
  output logic             dim_o
);

  logic shown_q;
  logic active;

  assign active  = !lp && shown_q && !dead;
  assign shown_o = shown_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_q <= 1'b0;
      bank_o  <= '0;
      seg_o   <= '0;
      dp_o    <= 1'b0;
      dim_o   <= 1'b0;
    end else begin
      if (upd_i) shown_q <= 1'b1;
      bank_o <= active ? bank_onehot(idx) : '0;
      seg_o  <= active ? seg : '0;
      dp_o   <= active && dp;
      dim_o  <= dim;
    end
  end

endmodule

// File: rtl/mux_display_scan.sv
module mux_display_scan
  import mux_scan_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned REFRESH_HZ = 1000,
  parameter int unsigned DWELL_CLKS = dwell_for(CLK_HZ, REFRESH_HZ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [DISP_W-1:0] disp_word,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [SEG_W-1:0]  seg_o,
  output logic              dp_o,
  output logic [BANKS-1:0]  bank_o,
  output logic              dim_o
);

  logic             low_power;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_dead;
  logic             scan_slot_end;
  logic             scan_shown;
  logic [SEG_W-1:0] sel_seg;
  logic             sel_dp;

  assign low_power = cfg_word[CFG_LP];

  scan_timer #(.DWELL(DWELL_CLKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (!low_power),
    .idx_o      (scan_idx),
    .dead_o     (scan_dead),
    .slot_end_o (scan_slot_end)
  );

  bank_select u_sel (
    .disp_word (disp_word),
    .cfg_word  (cfg_word),
    .idx       (scan_idx),
    .seg       (sel_seg),
    .dp        (sel_dp)
  );

  drive_stage u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd_i),
    .lp      (low_power),
    .dead    (scan_dead),
    .idx     (scan_idx),
    .seg     (sel_seg),
    .dp      (sel_dp),
    .dim     (cfg_word[CFG_DIM]),
    .shown_o (scan_shown),
    .bank_o  (bank_o),
    .seg_o   (seg_o),
    .dp_o    (dp_o),
    .dim_o   (dim_o)
  );

endmodule

// File: rtl/mux_scan_chk.sv
module mux_scan_chk
  import mux_scan_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_word,
  input logic [SEG_W-1:0] seg_o,
  input logic             dp_o,
  input logic [BANKS-1:0] bank_o,
  input logic             dim_o,
  input logic [IDX_W-1:0] scan_idx,
  input logic             scan_dead,
  input logic             scan_slot_end,
  input logic             scan_shown
);

  // R1
  blank_until_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_shown |=> bank_o == '0);

  // R2
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_slot_end |=> scan_idx != $past(scan_idx));

  // R3
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_o));

  // R3
  dead_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_dead |=> bank_o == '0);

  // R6
  last_bank_no_dp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_o[BANKS-1] |-> !dp_o);

  // R7
  low_power_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[CFG_LP] |=> (bank_o == '0 && seg_o == '0 && !dp_o));

  // R7
  low_power_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[CFG_LP] |=> $stable(scan_idx));

  // R8
  dim_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dim_o == $past(cfg_word[CFG_DIM]));

  // R9
  dark_segments_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_o == '0 |-> (seg_o == '0 && !dp_o));

endmodule

bind mux_display_scan mux_scan_chk u_chk (.*);

// File: tb/sim_mux_display_scan.sv
`timescale 1ns/1ps
module sim_mux_display_scan;

  localparam int DW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_i = 1'b0;
  logic [23:0] disp_word = '0;
  logic [6:0]  cfg_word = '0;
  logic [6:0]  seg_o;
  logic        dp_o;
  logic [4:0]  bank_o;
  logic        dim_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;

  always #2 clk = ~clk;

  mux_display_scan #(.DWELL_CLKS(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .disp_word(disp_word),
    .cfg_word(cfg_word), .seg_o(seg_o), .dp_o(dp_o), .bank_o(bank_o), .dim_o(dim_o)
  );

  function automatic string glyph(input logic [3:0] n);
    case (n)
      4'h0: return "abcdef";   4'h1: return "bc";
      4'h2: return "abdeg";    4'h3: return "abcdg";
      4'h4: return "bcfg";     4'h5: return "acdfg";
      4'h6: return "acdefg";   4'h7: return "abc";
      4'h8: return "abcdefg";  4'h9: return "abcdfg";
      4'hA: return "abcefg";   4'hB: return "cdefg";
      4'hC: return "adef";     4'hD: return "bcdeg";
      4'hE: return "adefg";    default: return "aefg";
    endcase
  endfunction

  function automatic logic [6:0] letters_to_seg(input string s);
    logic [6:0] v = '0;
    for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b1;
    return v;
  endfunction

  // Reference model, advanced at every rising edge
  int m_cnt, m_idx;
  bit m_shown;
  logic [4:0] e_bank;
  logic [6:0] e_seg;
  logic       e_dp, e_dim;
  string tag_bank, tag_seg, tag_dp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_shown = 0;
      e_bank = '0; e_seg = '0; e_dp = 0; e_dim = 0;
      tag_bank = "R1"; tag_seg = "R1"; tag_dp = "R1";
    end else begin
      bit lp, on;
      logic [3:0] nib;
      lp = cfg_word[0];
      on = !lp && m_shown && (m_cnt != 0);
      nib = disp_word[4*m_idx +: 4];
      if (on) begin
        e_bank = 5'(1) << m_idx;
        e_seg = cfg_word[1+m_idx] ? {3'b000, nib} : letters_to_seg(glyph(nib));
        e_dp = (m_idx < 4) ? disp_word[20+m_idx] : 1'b0;
        tag_bank = "R2";
        tag_seg = cfg_word[1+m_idx] ? "R5" : "R4";
        tag_dp = "R6";
      end else begin
        e_bank = '0; e_seg = '0; e_dp = 0;
        tag_bank = lp ? "R7" : (!m_shown ? "R1" : "R3");
        tag_seg = lp ? "R7" : "R9";
        tag_dp = tag_seg;
      end
      e_dim = cfg_word[6];
      if (upd_i) m_shown = 1;
      if (!lp) begin
        if (m_cnt == DW - 1) begin
          m_cnt = 0;
          m_idx = (m_idx == 4) ? 0 : m_idx + 1;
        end else m_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      check(bank_o === e_bank, tag_bank, "bank_o", int'(bank_o), int'(e_bank));
      check(seg_o === e_seg, tag_seg, "seg_o", int'(seg_o), int'(e_seg));
      check(dp_o === e_dp, tag_dp, "dp_o", int'(dp_o), int'(e_dp));
      check(dim_o === e_dim, "R8", "dim_o", int'(dim_o), int'(e_dim));
      if (bank_o == '0)
        check(seg_o == '0 && !dp_o, "R9", "dark segments", int'({dp_o, seg_o}), 0);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    disp_word = 24'hABCDEF;
    cfg_word = 7'h40;
    run(4);
    // R1: outputs dark during reset
    check(bank_o == '0 && seg_o == '0 && !dp_o && !dim_o, "R1", "reset state",
          int'({bank_o, seg_o}), 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    run(40);                          // R1: not yet written, stays dark
    upd_i = 1'b1; run(1); upd_i = 1'b0;
    disp_word = 24'hF_43210;          // R2 R4 R6: distinct nibbles per bank
    cfg_word = 7'h00;
    run(5 * DW * 2);
    for (int n = 0; n < 16; n++) begin // R4: every character on every bank
      disp_word = {4'(n), {5{4'(n)}}};
      run(5 * DW);
    end
    cfg_word = 7'b0_10101_0;           // R5: raw mode on banks 0, 2, 4
    disp_word = 24'h5_9C3A6;
    run(5 * DW * 2);
    cfg_word = 7'b1_00000_0;           // R8: dim
    run(DW + 3);
    cfg_word[0] = 1'b1;                // R7: freeze mid-slot
    run(23);
    cfg_word[0] = 1'b0;
    run(5 * DW * 2);
    rst_n = 1'b0; chk_en = 1'b0;       // R1: blank again after a new reset
    run(2);
    rst_n = 1'b1; chk_en = 1'b1;
    run(20);
    upd_i = 1'b1; run(1); upd_i = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 20 == 0) disp_word = 24'($urandom);
      if ($urandom % 40 == 0) begin
        cfg_word = 7'($urandom);
        cfg_word[0] = ($urandom % 4 == 0);
      end
      upd_i = ($urandom % 50 == 0);
      run(1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule